// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests for a small 16-bit CPU and holds them in a 16-bit pending register. At each instruction boundary it tells the instruction sequencer which handler vector to take. There are eight slots. Slot 0 is reset, slot 1 is the non-maskable external line, slot 2 is a bus-error report, and slot 4 is an arithmetic fault. Slot 7 is the maskable external request line. Slots 3, 5 and 6 are reserved and never latch. Slots 4 to 7 are gated by a 4-bit enable field that the sequencer supplies from its flag register. Slots 0 to 2 are never gated.

The sequencer raises `take_ready` when it reaches an instruction boundary. `take_valid` is high while some eligible request is pending. In a cycle where both are high, the sequencer accepts the offered `vec_addr` and `push_ret`, and it acts on the `mask_clr` and `flag_clr` strobes. The block then retires the served pending bit on the next clock edge. Back-pressure rules:
- While `take_ready` is low nothing is retired.
- The offer is recomputed every cycle. It may switch to a lower-numbered slot that latches later, or drop when the enable field closes.
- The sequencer therefore uses the offer only in the cycle it accepts it.

Reading the handler pointer from memory and pushing the return address are done by the sequencer. `pend_rd` gives software a read view of the pending register.

Top module: `intr_vector_unit`

## Requirements
- R1: `pend_rd` bit n shows pending slot n. The slots are: bit 0 reset, bit 1 non-maskable line, bit 2 bus error, bit 4 arithmetic fault and bit 7 external request. Bits 3, 5 and 6 and bits 15:8 always read 0.
- R2: After the asynchronous reset (`rst_n` low), `pend_rd` is 0x0001 and the block offers the reset vector 0x0000 with `push_ret` low.
- R3: The offered `vec_addr` is twice the slot index: reset 0x0000, non-maskable 0x0002, bus error 0x0004, arithmetic 0x0008, external request 0x000E.
- R4: When several eligible bits are pending, the lowest-numbered one is offered.
- R5: Slot k in 4..7 is eligible only while `irq_en[k-4]` is 1. Slots 0 to 2 are eligible regardless of `irq_en`. A pending bit whose enable is 0 stays latched but is not offered.
- R6: A request on slot 4 or 7 while its enable bit is 0 does not set its pending bit.
- R7: `take_valid` is high exactly when an eligible bit is pending. A cycle with `take_valid` and `take_ready` high clears the offered bit at the next edge. A request arriving in that same cycle is still latched. With `take_ready` low the register only gains bits.
- R8: During a handshake on slot k in 4..7, `mask_clr[k-4]` is pulsed for that one cycle. For slots 0 to 2, `mask_clr` stays 0.
- R9: A handshake on the reset slot pulses `flag_clr`, offers `push_ret` low, and clears the whole pending register except for requests arriving in that cycle. Any other slot offers `push_ret` high and leaves `flag_clr` low.
- R10: `bus_err_req` sets bit 2 only in a cycle where `mem_busy` is high.
- R11: `nmi_pin` and `irq_pin` pass through two synchronizer flops and a rising-edge detector. A rising input shows in `pend_rd` three clock edges later. An input held high sets the pending bit only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_req | input | 1 | Synchronous request for the reset slot |
| nmi_pin | input | 1 | Asynchronous non-maskable line |
| bus_err_req | input | 1 | Bus error report from the memory side |
| mem_busy | input | 1 | A memory cycle is in progress |
| arith_req | input | 1 | Arithmetic fault pulse |
| irq_pin | input | 1 | Asynchronous maskable request line |
| irq_en | input | 4 | Enables for slots 4..7 (bit 0 = slot 4) |
| take_valid | output | 1 | An eligible interrupt is offered |
| take_ready | input | 1 | Sequencer is at an instruction boundary and accepts |
| vec_addr | output | 16 | Address of the handler pointer |
| push_ret | output | 1 | Sequencer must push the return address |
| mask_clr | output | 4 | One-cycle strobe to clear an enable bit |
| flag_clr | output | 1 | One-cycle strobe to clear the flag register |
| pend_rd | output | 16 | Software view of the pending register |

## Verification
Directed sequences check each input in isolation:
- Masked and unmasked arithmetic pulses show whether the enable gate acts at latch time.
- Bus-error reports with and without `mem_busy` show the memory-cycle qualifier.
- Held external pins separate edge detection from level sensing.
- Several bits pending together, then drained one handshake at a time, show the priority order, the vector values and which strobe each slot raises.

A final stretch drives every input with pseudo-random values, and a behavioural model is compared every cycle. This exercises same-cycle latch-and-take collisions and enables that close while a bit is pending.

// File: rtl/intr_vector_pkg.sv
`timescale 1ns/1ps
package intr_vector_pkg;
  localparam int NSRC       = 8;
  localparam int REG_W      = 16;
  localparam int ADDR_W     = 16;
  localparam int MASK_LO    = 4;
  localparam int VEC_STRIDE = 2;
  localparam int SYNC_STG   = 2;
  // slot indices whose position is decoded by the sequencer
  localparam int SLOT_RESET = 0;
  localparam int SLOT_NMI   = 1;
  localparam int SLOT_BUS   = 2;
  localparam int SLOT_ARITH = 4;
  localparam int SLOT_EXT   = 7;
endpackage

// File: rtl/intr_edge_sync.sv
`timescale 1ns/1ps
module intr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/intr_prio_sel.sv
`timescale 1ns/1ps
module intr_prio_sel #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     elig,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    any = |elig;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/intr_pending_reg.sv
`timescale 1ns/1ps
module intr_pending_reg #(
  parameter int N = 8,
  parameter logic [N-1:0] RST_VAL = {{(N-1){1'b0}}, 1'b1}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_req,
  input  logic [N-1:0] clr_one,
  input  logic         clr_all,
  output logic [N-1:0] pend
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;

  // a new request always wins over a clear in the same cycle
  always_comb begin
    if (clr_all) pend_d = set_req;
    else         pend_d = (pend_q & ~clr_one) | set_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= RST_VAL;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/intr_vector_unit.sv
`timescale 1ns/1ps
module intr_vector_unit
  import intr_vector_pkg::*;
#(
  parameter int N_SLOT   = NSRC,
  parameter int PEND_W   = REG_W,
  parameter int VADDR_W  = ADDR_W,
  parameter int MASK_BASE = MASK_LO,
  parameter int STRIDE   = VEC_STRIDE,
  parameter int SYNC_N   = SYNC_STG
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rst_req,
  input  logic                          nmi_pin,
  input  logic                          bus_err_req,
  input  logic                          mem_busy,
  input  logic                          arith_req,
  input  logic                          irq_pin,
  input  logic [N_SLOT-MASK_BASE-1:0]   irq_en,
  output logic                          take_valid,
  input  logic                          take_ready,
  output logic [VADDR_W-1:0]            vec_addr,
  output logic                          push_ret,
  output logic [N_SLOT-MASK_BASE-1:0]   mask_clr,
  output logic                          flag_clr,
  output logic [PEND_W-1:0]             pend_rd
);
  localparam int IDX_W = $clog2(N_SLOT);
  localparam int N_MSK = N_SLOT - MASK_BASE;

  logic             nmi_rise, ext_rise;
  logic [N_SLOT-1:0] raw_req, gated_req, pend, elig, clr_one;
  logic             any_elig, fire, clr_all;
  logic [IDX_W-1:0] sel_idx;

  intr_edge_sync #(.STAGES(SYNC_N)) u_nmi_sync (
    .clk(clk), .rst_n(rst_n), .async_in(nmi_pin), .rise(nmi_rise));
  intr_edge_sync #(.STAGES(SYNC_N)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .async_in(irq_pin), .rise(ext_rise));

  // per-slot request sources; unlisted slots are reserved and stay idle
  always_comb begin
    raw_req             = '0;
    raw_req[SLOT_RESET] = rst_req;
    raw_req[SLOT_NMI]   = nmi_rise;
    raw_req[SLOT_BUS]   = bus_err_req & mem_busy;
    raw_req[SLOT_ARITH] = arith_req;
    raw_req[SLOT_EXT]   = ext_rise;
  end

  // maskable slots neither latch nor get offered while disabled
  for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
    if (i >= MASK_BASE) begin : g_msk
      assign gated_req[i] = raw_req[i] & irq_en[i-MASK_BASE];
      assign elig[i]      = pend[i] & irq_en[i-MASK_BASE];
    end else begin : g_nmsk
      assign gated_req[i] = raw_req[i];
      assign elig[i]      = pend[i];
    end
  end

  intr_prio_sel #(.N(N_SLOT), .IDX_W(IDX_W)) u_sel (
    .elig(elig), .any(any_elig), .idx(sel_idx));

  assign take_valid = any_elig;
  assign fire       = any_elig & take_ready;
  assign clr_all    = fire && (sel_idx == IDX_W'(SLOT_RESET));
  assign clr_one    = fire ? (N_SLOT'(1) << sel_idx) : '0;

  intr_pending_reg #(.N(N_SLOT)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_req(gated_req),
    .clr_one(clr_one), .clr_all(clr_all), .pend(pend));

  assign vec_addr = VADDR_W'(sel_idx) * VADDR_W'(STRIDE);
  assign push_ret = any_elig && (sel_idx != IDX_W'(SLOT_RESET));
  assign flag_clr = clr_all;

  for (genvar j = 0; j < N_MSK; j++) begin : g_mclr
    assign mask_clr[j] = fire && (sel_idx == IDX_W'(MASK_BASE + j));
  end

  assign pend_rd = PEND_W'(pend);
endmodule

// File: rtl/intr_vector_unit_chk.sv
`timescale 1ns/1ps
module intr_vector_unit_chk #(
  parameter int N_SLOT    = 8,
  parameter int PEND_W    = 16,
  parameter int VADDR_W   = 16,
  parameter int MASK_BASE = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        mem_busy,
  input logic                        arith_req,
  input logic [N_SLOT-MASK_BASE-1:0] irq_en,
  input logic                        take_valid,
  input logic                        take_ready,
  input logic [VADDR_W-1:0]          vec_addr,
  input logic                        push_ret,
  input logic [N_SLOT-MASK_BASE-1:0] mask_clr,
  input logic                        flag_clr,
  input logic [PEND_W-1:0]           pend_rd
);
  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pend_rd[PEND_W-1:N_SLOT] == '0 && !pend_rd[3] && !pend_rd[5] && !pend_rd[6]);

  assert_masked_nolatch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_rd[MASK_BASE] && !irq_en[0]) |=> !pend_rd[MASK_BASE]);

  assert_bus_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_rd[2] && !mem_busy) |=> !pend_rd[2]);

  assert_take_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && take_ready && vec_addr == VADDR_W'(2*MASK_BASE) && !arith_req)
      |=> !pend_rd[MASK_BASE]);

  assert_maskclr_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_clr));

  assert_reset_nopush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && vec_addr == '0) |-> !push_ret);

  assert_flagclr_hs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |-> (take_valid && take_ready));
endmodule

bind intr_vector_unit intr_vector_unit_chk #(
  .N_SLOT(N_SLOT), .PEND_W(PEND_W), .VADDR_W(VADDR_W), .MASK_BASE(MASK_BASE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_busy(mem_busy), .arith_req(arith_req),
  .irq_en(irq_en), .take_valid(take_valid), .take_ready(take_ready),
  .vec_addr(vec_addr), .push_ret(push_ret), .mask_clr(mask_clr),
  .flag_clr(flag_clr), .pend_rd(pend_rd)
);

// File: tb/intr_vector_unit_tb_top.sv
`timescale 1ns/1ps
module intr_vector_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_req = 0, nmi_pin = 0, bus_err_req = 0, mem_busy = 0;
  logic arith_req = 0, irq_pin = 0, take_ready = 0;
  logic [3:0] irq_en = 4'h0;
  logic take_valid, push_ret, flag_clr;
  logic [15:0] vec_addr, pend_rd;
  logic [3:0] mask_clr;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  intr_vector_unit dut_i (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .nmi_pin(nmi_pin),
    .bus_err_req(bus_err_req), .mem_busy(mem_busy), .arith_req(arith_req),
    .irq_pin(irq_pin), .irq_en(irq_en), .take_valid(take_valid),
    .take_ready(take_ready), .vec_addr(vec_addr), .push_ret(push_ret),
    .mask_clr(mask_clr), .flag_clr(flag_clr), .pend_rd(pend_rd));

  // behavioural reference model
  logic [7:0] m_pend;
  logic [2:0] m_nq, m_iq;   // [0] newest pin sample

  function automatic logic [7:0] m_elig();
    return m_pend & {irq_en, 4'hF};
  endfunction

  function automatic int m_sel();
    logic [7:0] e = m_elig();
    for (int i = 0; i < 8; i++) if (e[i]) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 8'h01; m_nq = 3'b0; m_iq = 3'b0;
    end else begin
      logic [7:0] sets;
      int s;
      sets = 8'h0;
      sets[0] = rst_req;
      sets[1] = m_nq[1] && !m_nq[2];
      sets[2] = bus_err_req && mem_busy;
      sets[4] = arith_req && irq_en[0];
      sets[7] = m_iq[1] && !m_iq[2] && irq_en[3];
      s = m_sel();
      if (s >= 0 && take_ready) begin
        if (s == 0) m_pend = sets;
        else        m_pend = (m_pend & ~(8'h01 << s)) | sets;
      end else begin
        m_pend = m_pend | sets;
      end
      m_nq = {m_nq[1:0], nmi_pin};
      m_iq = {m_iq[1:0], irq_pin};
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // compare every output with the model
  task automatic compare_all();
    int s;
    logic [3:0] e_mclr;
    s = m_sel();
    e_mclr = 4'h0;
    if (s >= 4 && take_ready) e_mclr[s-4] = 1'b1;
    chk(pend_rd == {8'h00, m_pend}, "R1 pend_rd", pend_rd, {8'h00, m_pend});
    chk(take_valid == (s >= 0), "R7 take_valid", 16'(take_valid), 16'(s >= 0));
    if (s >= 0) begin
      chk(vec_addr == 16'(2*s), "R3 R4 vec_addr", vec_addr, 16'(2*s));
      chk(push_ret == (s != 0), "R9 push_ret", 16'(push_ret), 16'(s != 0));
    end
    chk(mask_clr == e_mclr, "R8 mask_clr", 16'(mask_clr), 16'(e_mclr));
    chk(flag_clr == (s == 0 && take_ready), "R9 flag_clr", 16'(flag_clr),
        16'(s == 0 && take_ready));
  endtask

  task automatic tick();
    #5 compare_all();
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R2: power-up state
    chk(pend_rd == 16'h0001, "R2 reset pend", pend_rd, 16'h0001);
    chk(take_valid && vec_addr == 16'h0 && !push_ret, "R2 reset offer",
        {take_valid, push_ret, vec_addr[13:0]}, 16'h8000);
    @(negedge clk);
    // R7: without ready nothing retires
    ticks(2);
    chk(pend_rd == 16'h0001, "R7 hold without ready", pend_rd, 16'h0001);
    // R9: take reset
    take_ready = 1; tick(); take_ready = 0;
    chk(pend_rd == 16'h0000, "R9 reset take clears", pend_rd, 16'h0000);
    // R6: masked arithmetic fault
    arith_req = 1; tick(); arith_req = 0; tick();
    chk(pend_rd == 16'h0000, "R6 masked fault ignored", pend_rd, 16'h0000);
    // R5: enabled fault latches
    irq_en = 4'b0001;
    arith_req = 1; tick(); arith_req = 0;
    chk(pend_rd == 16'h0010, "R5 enabled fault latches", pend_rd, 16'h0010);
    // R5: closing the enable hides but keeps the bit
    irq_en = 4'b0000; #1;
    chk(!take_valid, "R5 disabled not offered", 16'(take_valid), 16'h0);
    tick();
    chk(pend_rd == 16'h0010, "R5 disabled stays latched", pend_rd, 16'h0010);
    irq_en = 4'b0001;
    // R10: bus error gated by memory cycle
    bus_err_req = 1; tick(); bus_err_req = 0;
    chk(pend_rd == 16'h0010, "R10 bus error outside cycle", pend_rd, 16'h0010);
    mem_busy = 1; bus_err_req = 1; tick(); bus_err_req = 0; mem_busy = 0;
    chk(pend_rd == 16'h0014, "R10 bus error in cycle", pend_rd, 16'h0014);
    // R4 / R3: bus error served before arithmetic
    #1;
    chk(vec_addr == 16'h0004, "R4 lowest first", vec_addr, 16'h0004);
    take_ready = 1; #1;
    chk(mask_clr == 4'h0 && push_ret, "R8 nonmaskable no strobe",
        {push_ret, 11'h0, mask_clr}, 16'h8000);
    tick();
    chk(vec_addr == 16'h0008 && mask_clr == 4'b0001, "R8 maskable strobe",
        {vec_addr[11:0], mask_clr}, 16'h0081);
    tick(); take_ready = 0;
    chk(pend_rd == 16'h0000, "R7 drained", pend_rd, 16'h0000);
    // R11: held NMI line latches once, three edges later
    nmi_pin = 1; ticks(2);
    chk(pend_rd == 16'h0000, "R11 not yet through sync", pend_rd, 16'h0000);
    tick();
    chk(pend_rd == 16'h0002, "R11 nmi latched", pend_rd, 16'h0002);
    take_ready = 1; tick(); take_ready = 0;
    ticks(5);
    chk(pend_rd == 16'h0000, "R11 held level latches once", pend_rd, 16'h0000);
    nmi_pin = 0; ticks(3);
    // R3 / R8: external request slot
    irq_en = 4'b1000;
    irq_pin = 1; ticks(3); irq_pin = 0;
    chk(pend_rd == 16'h0080, "R11 irq latched", pend_rd, 16'h0080);
    take_ready = 1; #1;
    chk(vec_addr == 16'h000E && mask_clr == 4'b1000, "R3 irq vector",
        {vec_addr[11:0], mask_clr}, 16'h00E8);
    tick(); take_ready = 0; ticks(3);
    // R9: software reset wipes other pending bits
    irq_en = 4'b0001;
    arith_req = 1; tick(); arith_req = 0;
    mem_busy = 1; bus_err_req = 1; tick(); bus_err_req = 0; mem_busy = 0;
    rst_req = 1; tick(); rst_req = 0;
    chk(pend_rd == 16'h0015, "R9 three pending", pend_rd, 16'h0015);
    take_ready = 1; #1;
    chk(flag_clr && !push_ret, "R9 reset strobe", {flag_clr, push_ret}, 16'h2);
    tick(); take_ready = 0;
    chk(pend_rd == 16'h0000, "R9 whole register cleared", pend_rd, 16'h0000);
    // R7: request colliding with take of the same slot stays latched
    arith_req = 1; tick();
    take_ready = 1; tick(); take_ready = 0; arith_req = 0;
    chk(pend_rd == 16'h0010, "R7 collision keeps request", pend_rd, 16'h0010);
    // random phase, model compared each cycle
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom;
      rst_req     = (r[3:0] == 4'h0);
      nmi_pin     = r[4] ^ (r[5] & nmi_pin);
      bus_err_req = r[6];
      mem_busy    = r[7];
      arith_req   = r[8] & r[9];
      irq_pin     = r[10] ^ (r[11] & irq_pin);
      if (r[15:12] == 4'h0) irq_en = r[19:16];
      take_ready  = r[20] & r[21];
      tick();
    end
    rst_req = 0; take_ready = 0; tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule